// File: doc/BRIEF.md
# Multiplexed LCD Waveform Controller

This block produces the digital drive for a four-common, sixteen-segment multiplexed liquid-crystal panel. For every pin it outputs a two-bit level code in each time slot. A resistor ladder or analog buffer outside the block turns that code into a voltage. A 64-bit display memory holds one bit per common/segment crossing. The block supports two schemes, both at quarter duty: half bias and third bias. The third-bias scheme runs its frames twice as fast.

Frame timing comes from a slow base tick, nominally 32 kHz. A frame has four common slots, and the polarity of the drive inverts on every frame so that each pin averages to zero DC over two frames. Memory writes, the display-enable command and the bias choice are held until the next frame boundary, so a frame is never drawn half old and half new. After reset, or after the clock-stop request is released, every pin carries the non-select waveform and the display-enable command is cleared. Common scanning starts only once software enables the display again. The block also drives per-pin select flags that tell the pad multiplexer whether each pin serves the panel or general I/O.

Top module: `lcdmux_drive`

## Requirements
- R1: While rst_n is low, and on each clock edge where stop_i is high, the block resets its timer, clears the display-enable command and the displayed enable, and sets polarity to 0. The memory contents and the latched bias are kept. With tick_i held high, the first polarity toggle after release comes exactly four slot lengths of edges later.
- R2: A slot lasts SLOT_TICKS ticks in half-bias mode and SLOT_TICKS/2 ticks in third-bias mode. Four slots make one frame. The timer advances only on clock edges where tick_i is high.
- R3: pol_o inverts at every frame boundary, after slot 3 of the frame ends.
- R4: In half-bias mode, each common n is 2 bits wide at com_lvl_o[2n+1:2n]. A selected common drives 11 (full) when pol_o is 0 and 00 (ground) when pol_o is 1. A non-selected common drives 01 (mid level). At most one common is selected at a time.
- R5: In half-bias mode, each segment s is at seg_lvl_o[2s+1:2s]. An "on" segment drives 00 when pol_o is 0 and 11 when pol_o is 1. An "off" segment drives 11 when pol_o is 0 and 00 when pol_o is 1. No other code appears on a segment.
- R6: In third-bias mode, a selected common drives 11 when pol_o is 0 and 00 when pol_o is 1. A non-selected common drives 01 (1/3) when pol_o is 0 and 10 (2/3) when pol_o is 1.
- R7: In third-bias mode, an "on" segment drives 00 when pol_o is 0 and 11 when pol_o is 1. An "off" segment drives 10 when pol_o is 0 and 01 when pol_o is 1.
- R8: In slot k, common k is selected, and segment s is "on" when memory bit s*4+k is 1. When the displayed enable is 0, no common is selected and every segment is "off".
- R9: A memory write puts mem_data_i[k] into bit mem_addr_i*4+k. The write, the display command (disp_on_i, taken when disp_wr_i is high) and the bias3_i level all take effect on the frame boundary that follows them, and not before.
- R10: com_sel_o and the low four bits of seg_sel_o are all 1 when lcd_off_i is 0 and all 0 when it is 1. Bits 4 to 15 of seg_sel_o follow seg_cfg_i bits 0 to 11, whatever lcd_off_i is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Base time tick enable |
| stop_i | input | 1 | Clock-stop request; restarts the block as described in R1 |
| bias3_i | input | 1 | Bias select: 0 half bias, 1 third bias |
| lcd_off_i | input | 1 | 1 returns the commons and segments 0-3 to general I/O |
| seg_cfg_i | input | 12 | Per-pin panel select for segments 4-15 |
| disp_wr_i | input | 1 | Strobe that writes the display command |
| disp_on_i | input | 1 | Display command value |
| mem_wr_i | input | 1 | Display memory write strobe |
| mem_addr_i | input | 4 | Segment index being written |
| mem_data_i | input | 4 | One bit per common for that segment |
| com_lvl_o | output | 8 | Common level codes, 2 bits per common |
| seg_lvl_o | output | 32 | Segment level codes, 2 bits per segment |
| com_sel_o | output | 4 | Common pins serve the panel |
| seg_sel_o | output | 16 | Segment pins serve the panel |
| pol_o | output | 1 | Current frame polarity |

## Verification
The level outputs are decoded from registered state, so a change of state made on a clock edge shows at the pins during that same cycle. The bench therefore samples on falling edges. For memory, display command and bias, the expected change is due only after the frame-boundary edge. The bench finds that edge by watching pol_o flip, then steps exactly one slot length of edges (four or two in the bench build) between slot checks, so a wrong slot length puts every later sample in the wrong slot. After a stop, the bench counts exactly eight edges to the first toggle. Pin-select flags are combinational and are checked in the cycle their inputs change.

// File: rtl/lcdmux_pkg.sv
package lcdmux_pkg;
    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_GND  = 2'b00;
    localparam lvl_t LVL_LO   = 2'b01;
    localparam lvl_t LVL_HI   = 2'b10;
    localparam lvl_t LVL_FULL = 2'b11;

    // common pin code for one slot
    function automatic lvl_t com_code(input logic bias3, input logic pol, input logic sel);
        if (sel)        return pol ? LVL_GND : LVL_FULL;
        else if (bias3) return pol ? LVL_HI  : LVL_LO;
        else            return LVL_LO;
    endfunction

    // segment pin code for one slot
    function automatic lvl_t seg_code(input logic bias3, input logic pol, input logic on);
        if (on)         return pol ? LVL_FULL : LVL_GND;
        else if (bias3) return pol ? LVL_LO   : LVL_HI;
        else            return pol ? LVL_GND  : LVL_FULL;
    endfunction
endpackage

// File: rtl/lcdmux_timer.sv
module lcdmux_timer #(
    parameter int NCOM       = 4,
    parameter int SLOT_TICKS = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stop_i,
    input  logic                    tick_i,
    input  logic                    bias3_i,
    output logic [$clog2(NCOM)-1:0] slot_o,
    output logic                    pol_o,
    output logic                    bound_o
);
    localparam int CNT_W  = (SLOT_TICKS > 2) ? $clog2(SLOT_TICKS) : 1;
    localparam int SLOT_W = $clog2(NCOM);
    localparam logic [CNT_W-1:0]  LEN_FULL  = CNT_W'(SLOT_TICKS - 1);
    localparam logic [CNT_W-1:0]  LEN_HALF  = CNT_W'(SLOT_TICKS / 2 - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NCOM - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
        logic              pol;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic bound_d;

    always_comb begin
        tmr_d   = tmr_q;
        bound_d = 1'b0;
        if (stop_i) begin
            tmr_d = '0;
        end else if (tick_i) begin
            if (tmr_q.cnt == (bias3_i ? LEN_HALF : LEN_FULL)) begin
                tmr_d.cnt = '0;
                if (tmr_q.slot == SLOT_LAST) begin
                    tmr_d.slot = '0;
                    tmr_d.pol  = ~tmr_q.pol;
                    bound_d    = 1'b1;
                end else begin
                    tmr_d.slot = tmr_q.slot + 1'b1;
                end
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign slot_o  = tmr_q.slot;
    assign pol_o   = tmr_q.pol;
    assign bound_o = bound_d;
endmodule

// File: rtl/lcdmux_levels.sv
module lcdmux_levels
    import lcdmux_pkg::*;
#(
    parameter int NCOM = 4,
    parameter int NSEG = 16
) (
    input  logic                    bias3_i,
    input  logic                    pol_i,
    input  logic                    disp_i,
    input  logic [$clog2(NCOM)-1:0] slot_i,
    input  logic [NSEG-1:0]         seg_on_i,
    output logic [2*NCOM-1:0]       com_lvl_o,
    output logic [2*NSEG-1:0]       seg_lvl_o
);
    localparam int SLOT_W = $clog2(NCOM);

    for (genvar c = 0; c < NCOM; c++) begin : g_com
        logic sel;
        assign sel = disp_i && (slot_i == SLOT_W'(c));
        assign com_lvl_o[2*c +: 2] = com_code(bias3_i, pol_i, sel);
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign seg_lvl_o[2*s +: 2] = seg_code(bias3_i, pol_i, disp_i && seg_on_i[s]);
    end
endmodule

// File: rtl/lcdmux_drive.sv
module lcdmux_drive #(
    parameter int NCOM       = 4,
    parameter int NSEG       = 16,
    parameter int NGRP       = 4,
    parameter int SLOT_TICKS = 128
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick_i,
    input  logic                    stop_i,
    input  logic                    bias3_i,
    input  logic                    lcd_off_i,
    input  logic [NSEG-NGRP-1:0]    seg_cfg_i,
    input  logic                    disp_wr_i,
    input  logic                    disp_on_i,
    input  logic                    mem_wr_i,
    input  logic [$clog2(NSEG)-1:0] mem_addr_i,
    input  logic [NCOM-1:0]         mem_data_i,
    output logic [2*NCOM-1:0]       com_lvl_o,
    output logic [2*NSEG-1:0]       seg_lvl_o,
    output logic [NCOM-1:0]         com_sel_o,
    output logic [NSEG-1:0]         seg_sel_o,
    output logic                    pol_o
);
    localparam int ADDR_W = $clog2(NSEG);
    localparam int SLOT_W = $clog2(NCOM);
    localparam int NBITS  = NCOM * NSEG;

    typedef struct packed {
        logic             disp_cmd;
        logic             disp_act;
        logic             bias3;
        logic [NBITS-1:0] shadow;
        logic [NBITS-1:0] active;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [SLOT_W-1:0] slot;
    logic              bound;
    logic [NSEG-1:0]   seg_on;

    lcdmux_timer #(.NCOM(NCOM), .SLOT_TICKS(SLOT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .stop_i  (stop_i),
        .tick_i  (tick_i),
        .bias3_i (st_q.bias3),
        .slot_o  (slot),
        .pol_o   (pol_o),
        .bound_o (bound)
    );

    always_comb begin
        st_d = st_q;
        if (disp_wr_i) st_d.disp_cmd = disp_on_i;
        for (int s = 0; s < NSEG; s++) begin
            if (mem_wr_i && (mem_addr_i == ADDR_W'(s)))
                st_d.shadow[s*NCOM +: NCOM] = mem_data_i;
        end
        if (bound) begin
            st_d.disp_act = st_q.disp_cmd;
            st_d.bias3    = bias3_i;
            st_d.active   = st_q.shadow;
        end
        if (stop_i) begin
            st_d.disp_cmd = 1'b0;
            st_d.disp_act = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int s = 0; s < NSEG; s++)
            seg_on[s] = st_q.active[s*NCOM + int'(slot)];
    end

    lcdmux_levels #(.NCOM(NCOM), .NSEG(NSEG)) u_levels (
        .bias3_i   (st_q.bias3),
        .pol_i     (pol_o),
        .disp_i    (st_q.disp_act),
        .slot_i    (slot),
        .seg_on_i  (seg_on),
        .com_lvl_o (com_lvl_o),
        .seg_lvl_o (seg_lvl_o)
    );

    for (genvar p = 0; p < NSEG; p++) begin : g_segsel
        if (p < NGRP) begin : g_grp
            assign seg_sel_o[p] = ~lcd_off_i;
        end else begin : g_own
            assign seg_sel_o[p] = seg_cfg_i[p-NGRP];
        end
    end
    assign com_sel_o = {NCOM{~lcd_off_i}};
endmodule

// File: rtl/lcdmux_chk.sv
module lcdmux_chk #(
    parameter int NCOM = 4,
    parameter int NSEG = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              stop_i,
    input logic              pol_o,
    input logic              bias3_q,
    input logic [2*NCOM-1:0] com_lvl_o,
    input logic [2*NSEG-1:0] seg_lvl_o
);
    logic [NCOM-1:0] sel_v;
    logic            seg_mid;

    always_comb begin
        for (int c = 0; c < NCOM; c++)
            sel_v[c] = (com_lvl_o[2*c +: 2] == (pol_o ? 2'b00 : 2'b11));
        seg_mid = 1'b0;
        for (int s = 0; s < NSEG; s++)
            if (seg_lvl_o[2*s +: 2] == 2'b01 || seg_lvl_o[2*s +: 2] == 2'b10)
                seg_mid = 1'b1;
    end

    // R2: polarity moves only after a tick or a stop
    p_pol_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_o) |-> ($past(tick_i) || $past(stop_i)));

    // R4: never more than one common selected
    p_one_common_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_v));

    // R5: half bias segments are two-level only
    p_seg_twolevel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bias3_q |-> !seg_mid);

    // R1: after a stop edge no common is selected
    p_stop_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_i) |-> (sel_v == '0));
endmodule

bind lcdmux_drive lcdmux_chk #(.NCOM(NCOM), .NSEG(NSEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .stop_i    (stop_i),
    .pol_o     (pol_o),
    .bias3_q   (st_q.bias3),
    .com_lvl_o (com_lvl_o),
    .seg_lvl_o (seg_lvl_o)
);

// File: tb/tb_lcdmux_drive.sv
module tb_lcdmux_drive;
    localparam int  SLOT = 4;
    localparam time CLK  = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        stop_i = 1'b0;
    logic        bias3_i = 1'b0;
    logic        lcd_off_i = 1'b0;
    logic [11:0] seg_cfg_i = '0;
    logic        disp_wr_i = 1'b0;
    logic        disp_on_i = 1'b0;
    logic        mem_wr_i = 1'b0;
    logic [3:0]  mem_addr_i = '0;
    logic [3:0]  mem_data_i = '0;
    logic [7:0]  com_lvl_o;
    logic [31:0] seg_lvl_o;
    logic [3:0]  com_sel_o;
    logic [15:0] seg_sel_o;
    logic        pol_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [63:0] shadow_m = '0;
    logic [63:0] act_m    = '0;

    lcdmux_drive #(.SLOT_TICKS(SLOT)) dut (.*);

    always #(CLK/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] e_com(bit b3, bit p, bit sel);
        if (sel) return p ? 2'b00 : 2'b11;
        if (b3)  return p ? 2'b10 : 2'b01;
        return 2'b01;
    endfunction

    function automatic logic [1:0] e_seg(bit b3, bit p, bit on);
        if (on) return p ? 2'b11 : 2'b00;
        if (b3) return p ? 2'b01 : 2'b10;
        return p ? 2'b00 : 2'b11;
    endfunction

    function automatic logic [7:0] e_coms(bit b3, bit p, bit dsp, int slot);
        logic [7:0] v;
        for (int c = 0; c < 4; c++) v[2*c +: 2] = e_com(b3, p, dsp && (c == slot));
        return v;
    endfunction

    function automatic logic [31:0] e_segs(bit b3, bit p, bit dsp, int slot);
        logic [31:0] v;
        for (int s = 0; s < 16; s++) v[2*s +: 2] = e_seg(b3, p, dsp && act_m[s*4 + slot]);
        return v;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic sync_frame();
        logic p;
        p = pol_o;
        while (pol_o == p) @(negedge clk);
    endtask

    // checks one slot here, then steps one slot length
    task automatic chk_slot(bit b3, bit p, bit dsp, int slot, int len, string req);
        logic [7:0]  ec;
        logic [31:0] es;
        ec = e_coms(b3, p, dsp, slot);
        es = e_segs(b3, p, dsp, slot);
        chk(com_lvl_o == ec, req, 32'(com_lvl_o), 32'(ec));
        chk(seg_lvl_o == es, req, seg_lvl_o, es);
        repeat (len) @(negedge clk);
    endtask

    // aligned at a frame start: checks n frames and each polarity toggle (R3)
    task automatic run_frames(bit b3, bit dsp, int n, int len, string req);
        for (int f = 0; f < n; f++) begin
            logic p;
            p = pol_o;
            for (int s = 0; s < 4; s++) chk_slot(b3, p, dsp, s, len, req);
            chk(pol_o == ~p, "R3 polarity toggle", 32'(pol_o), 32'(~p));
        end
    endtask

    task automatic wr_seg(int s, logic [3:0] d);
        mem_wr_i   = 1'b1;
        mem_addr_i = 4'(s);
        mem_data_i = d;
        @(negedge clk);
        mem_wr_i = 1'b0;
        shadow_m[s*4 +: 4] = d;
    endtask

    task automatic t_reset();
        chk(pol_o == 1'b0, "R1 reset polarity", 32'(pol_o), 0);
        chk(com_lvl_o == 8'h55, "R1 reset commons non-select", 32'(com_lvl_o), 32'h55);
        chk(seg_lvl_o == 32'hFFFF_FFFF, "R1 reset segments off", seg_lvl_o, 32'hFFFF_FFFF);
        chk(com_sel_o == 4'hF, "R10 commons to panel", 32'(com_sel_o), 32'hF);
        chk(seg_sel_o == 16'h000F, "R10 grouped segments to panel", 32'(seg_sel_o), 32'h000F);
    endtask

    task automatic t_disp_off();
        sync_frame();
        run_frames(0, 0, 2, SLOT, "R8 R2 display off frames");
    endtask

    task automatic t_mode0_on();
        for (int s = 0; s < 16; s++) wr_seg(s, 4'((s * 5 + 3) & 15));
        disp_wr_i = 1'b1;
        disp_on_i = 1'b1;
        @(negedge clk);
        disp_wr_i = 1'b0;
        sync_frame();
        act_m = shadow_m;
        run_frames(0, 1, 2, SLOT, "R4 R5 R8 R9 half bias scan");
    endtask

    task automatic t_tick_gate();
        logic [7:0] c0;
        logic       p0;
        c0 = com_lvl_o;
        p0 = pol_o;
        tick_i = 1'b0;
        repeat (30) @(negedge clk);
        chk(com_lvl_o == c0, "R2 no advance without tick", 32'(com_lvl_o), 32'(c0));
        chk(pol_o == p0, "R2 polarity held without tick", 32'(pol_o), 32'(p0));
        tick_i = 1'b1;
        run_frames(0, 1, 1, SLOT, "R2 resume after tick gap");
    endtask

    task automatic t_shadow();
        logic p;
        p = pol_o;
        wr_seg(7, ~act_m[28 +: 4]);
        wr_seg(0, ~act_m[0 +: 4]);
        repeat (SLOT - 2) @(negedge clk);
        for (int s = 1; s < 4; s++) chk_slot(0, p, 1, s, SLOT, "R9 write held to boundary");
        act_m = shadow_m;
        run_frames(0, 1, 1, SLOT, "R9 write shown after boundary");
    endtask

    task automatic t_mode1();
        bias3_i = 1'b1;
        run_frames(0, 1, 1, SLOT, "R9 bias held to boundary");
        run_frames(1, 1, 2, SLOT/2, "R6 R7 R2 third bias scan");
    endtask

    task automatic t_pinsel();
        lcd_off_i = 1'b1;
        seg_cfg_i = 12'hA5C;
        #1;
        chk(com_sel_o == 4'h0, "R10 commons to I/O", 32'(com_sel_o), 0);
        chk(seg_sel_o == 16'hA5C0, "R10 segment selects", 32'(seg_sel_o), 32'hA5C0);
        lcd_off_i = 1'b0;
        seg_cfg_i = 12'h3F1;
        #1;
        chk(com_sel_o == 4'hF, "R10 commons back to panel", 32'(com_sel_o), 32'hF);
        chk(seg_sel_o == 16'h3F1F, "R10 segment selects group on", 32'(seg_sel_o), 32'h3F1F);
    endtask

    task automatic t_stop();
        repeat (3) @(negedge clk);
        stop_i = 1'b1;
        repeat (3) @(negedge clk);
        stop_i = 1'b0;
        chk(pol_o == 1'b0, "R1 stop polarity", 32'(pol_o), 0);
        chk(com_lvl_o == 8'h55, "R1 stop commons non-select", 32'(com_lvl_o), 32'h55);
        chk(seg_lvl_o == 32'hAAAA_AAAA, "R1 stop segments off", seg_lvl_o, 32'hAAAA_AAAA);
        repeat (4 * (SLOT/2) - 1) @(negedge clk);
        chk(pol_o == 1'b0, "R1 timer restart early", 32'(pol_o), 0);
        @(negedge clk);
        chk(pol_o == 1'b1, "R1 timer restart toggle", 32'(pol_o), 1);
        run_frames(1, 0, 1, SLOT/2, "R1 R8 display stays off");
        disp_wr_i = 1'b1;
        disp_on_i = 1'b1;
        @(negedge clk);
        disp_wr_i = 1'b0;
        sync_frame();
        run_frames(1, 1, 1, SLOT/2, "R9 display resumes at boundary");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_disp_off();
        t_mode0_on();
        t_tick_gate();
        t_shadow();
        t_mode1();
        t_pinsel();
        t_stop();
        finish_run();
    end

    initial begin
        #(CLK * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule